// File: doc/BRIEF.md
# Threshold-Serviced Data Buffer with DMA Requests

This block is a 32-word by 16-bit circular buffer placed between a processor data register and a card data engine. One side fills it and the other drains it, chosen by a direction input. In receive direction the card engine pushes words and the processor pops them. In transmit direction the processor pushes and the card engine pops. The buffer is tracked by a head pointer and a fill count, and every index wraps modulo 32.

Two programmable levels decide when the buffer asks for service. In receive direction the buffer asks to be drained once it holds more words than the almost-full level. In transmit direction it asks to be refilled once it holds fewer words than the almost-empty level. Each direction has its own DMA enable, which routes the request either to a level DMA request line or to a software-visible service flag. When no transfer is running and the buffer is empty, every request and flag is quiet.

Occupancy is held in a three-state machine. `OCC_EMPTY` goes to `OCC_PARTIAL` on an accepted push. `OCC_PARTIAL` goes to `OCC_EMPTY` when its last word is popped, and to `OCC_FULL` when its 32nd word is pushed. `OCC_FULL` goes back to `OCC_PARTIAL` on a pop. In every other case the state holds. The count and the state both change on the clock edge that accepts the push or pop. The threshold outputs follow from the registered state in the same cycle, through logic only.

Top module: `tfq_top`

## Requirements
- R1: Words leave the buffer in the order they were accepted, including when the head pointer wraps from slot 31 to slot 0; `rd_data` always shows the word at the head.
- R2: The control word has this layout: bit 15 is the receive DMA enable, bits 12:8 are the almost-full level, bit 7 is the transmit DMA enable, and bits 4:0 are the almost-empty level. `ctrl_rdata` returns these fields in the same positions, with every other bit reading 0.
- R3: After reset the fill count is 0, the almost-full level is 31, the almost-empty level is 0, and both DMA enables are 0, so `ctrl_rdata` reads 16'h1F00. All four service outputs are low.
- R4: In receive direction (`dir_rx`=1), when the count is greater than the almost-full level, `rx_dma_req` is high if receive DMA is enabled; otherwise `rx_svc_flag` is high. When the count is not greater than the level, both are low.
- R5: In transmit direction (`dir_rx`=0), when the count is less than the almost-empty level, `tx_dma_req` is high if transmit DMA is enabled; otherwise `tx_svc_flag` is high. When the count is not less than the level, both are low.
- R6: When `xfer_active` is low and the count is 0, all four service outputs are low, whatever the levels are.
- R7: A control write with a DMA enable set clears the matching service flag from the next cycle, and the request line takes over if the condition still holds.
- R8: A push while the count is 32 is dropped, and the count stays at 32.
- R9: A pop while the count is 0 changes neither the count nor `rd_data`.
- R10: In receive direction only `eng_push` and `cpu_rd` act on the buffer; in transmit direction only `cpu_wr` and `eng_pop` act. A push and a pop in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_active | input | 1 | A data transfer is in progress |
| dir_rx | input | 1 | 1 = receive (card to processor), 0 = transmit |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word to write |
| ctrl_rdata | output | 16 | Control word readback |
| cpu_wr | input | 1 | Processor push (transmit direction) |
| cpu_wdata | input | 16 | Processor push data |
| cpu_rd | input | 1 | Processor pop (receive direction) |
| eng_push | input | 1 | Card engine push (receive direction) |
| eng_wdata | input | 16 | Card engine push data |
| eng_pop | input | 1 | Card engine pop (transmit direction) |
| rd_data | output | 16 | Word at the head of the buffer |
| fill_count | output | 6 | Number of words held, 0 to 32 |
| rx_svc_flag | output | 1 | Receive service flag (status bit 10) |
| tx_svc_flag | output | 1 | Transmit service flag (status bit 11) |
| rx_dma_req | output | 1 | Receive DMA request, level |
| tx_dma_req | output | 1 | Transmit DMA request, level |

## Verification
The bench fills the buffer past 32 words after the head has already moved one slot. A design that let a write through when full would overwrite the oldest word, and the scoreboard would see the order break at the wrap. It pops an empty buffer and expects `rd_data` and the count to hold; a design that moved the pointer would change `rd_data`. It crosses each threshold in both directions, both with and without the DMA enable, and then sets the enable while a flag is up. A design with a strict/non-strict mix-up, or one that kept the flag after the enable was set, would show the wrong output one cycle later. It also drives the processor strobes that belong to the other direction and a same-cycle push and pop, where a wrong source mux or count update moves the count.

// File: rtl/tfq_pkg.sv
package tfq_pkg;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 32;
    localparam int LVL_W  = $clog2(DEPTH);
    localparam int CNT_W  = LVL_W + 1;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

    typedef struct packed {
        logic             rx_dma_en;
        logic [LVL_W-1:0] af_lvl;
        logic             tx_dma_en;
        logic [LVL_W-1:0] ae_lvl;
    } ctrl_t;
endpackage

// File: rtl/tfq_store.sv
module tfq_store
    import tfq_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = DEPTH,
    localparam int PW = $clog2(N),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [N];
    logic [PW-1:0] head_q;
    logic [CW-1:0] cnt_q;
    occ_e          occ_q, occ_d;
    logic          push_ok, pop_ok;
    logic [PW-1:0] tail;

    assign push_ok   = push && (occ_q != OCC_FULL);
    assign pop_ok    = pop  && (occ_q != OCC_EMPTY);
    assign tail      = head_q + cnt_q[PW-1:0];
    assign head_data = mem[head_q];
    assign count     = cnt_q;

    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY:   if (push_ok) occ_d = OCC_PARTIAL;
            OCC_PARTIAL: begin
                if (pop_ok && !push_ok && cnt_q == CW'(1))
                    occ_d = OCC_EMPTY;
                else if (push_ok && !pop_ok && cnt_q == CW'(N - 1))
                    occ_d = OCC_FULL;
            end
            OCC_FULL:    if (pop_ok) occ_d = OCC_PARTIAL;
            default:     occ_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= OCC_EMPTY;
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            occ_q <= occ_d;
            if (pop_ok) head_q <= head_q + PW'(1);
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + CW'(1);
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[tail] <= push_data;
    end

    // R1: the count never exceeds the depth, and the state agrees with it
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(N));
    a_r1_full_state: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_FULL) == (cnt_q == CW'(N)));
    // R8: a push into a full buffer is dropped
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(N) && push && !pop) |=> (cnt_q == CW'(N)));
    // R9: a pop from an empty buffer moves nothing
    a_r9_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && pop && !push) |=> (cnt_q == '0 && $stable(head_q)));
endmodule

// File: rtl/tfq_thresh.sv
module tfq_thresh
    import tfq_pkg::*;
#(
    parameter int LW = LVL_W,
    localparam int CW = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_active,
    input  logic          dir_rx,
    input  logic [CW-1:0] count,
    input  logic          rx_dma_en,
    input  logic [LW-1:0] af_lvl,
    input  logic          tx_dma_en,
    input  logic [LW-1:0] ae_lvl,
    output logic          rx_svc_flag,
    output logic          tx_svc_flag,
    output logic          rx_dma_req,
    output logic          tx_dma_req
);
    logic quiet, rx_hit, tx_hit;

    assign quiet  = !xfer_active && (count == '0);
    assign rx_hit = !quiet &&  dir_rx && (count > {1'b0, af_lvl});
    assign tx_hit = !quiet && !dir_rx && (count < {1'b0, ae_lvl});

    always_comb begin
        rx_dma_req  = rx_hit &&  rx_dma_en;
        rx_svc_flag = rx_hit && !rx_dma_en;
        tx_dma_req  = tx_hit &&  tx_dma_en;
        tx_svc_flag = tx_hit && !tx_dma_en;
    end

    // R6: idle and empty keeps every service output low
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && count == '0) |->
        !(rx_svc_flag || tx_svc_flag || rx_dma_req || tx_dma_req));
    // R4 / R5: one direction, one route at a time
    a_r4_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_svc_flag, tx_svc_flag, rx_dma_req, tx_dma_req}));
endmodule

// File: rtl/tfq_top.sv
module tfq_top
    import tfq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_active,
    input  logic              dir_rx,
    input  logic              ctrl_wr,
    input  logic [15:0]       ctrl_wdata,
    output logic [15:0]       ctrl_rdata,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              eng_push,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fill_count,
    output logic              rx_svc_flag,
    output logic              tx_svc_flag,
    output logic              rx_dma_req,
    output logic              tx_dma_req
);
    ctrl_t             ctrl_q;
    logic              push, pop;
    logic [DATA_W-1:0] push_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.rx_dma_en <= 1'b0;
            ctrl_q.af_lvl    <= '1;
            ctrl_q.tx_dma_en <= 1'b0;
            ctrl_q.ae_lvl    <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.rx_dma_en <= ctrl_wdata[15];
            ctrl_q.af_lvl    <= ctrl_wdata[8 +: LVL_W];
            ctrl_q.tx_dma_en <= ctrl_wdata[7];
            ctrl_q.ae_lvl    <= ctrl_wdata[0 +: LVL_W];
        end
    end

    always_comb begin
        ctrl_rdata               = '0;
        ctrl_rdata[15]           = ctrl_q.rx_dma_en;
        ctrl_rdata[8 +: LVL_W]   = ctrl_q.af_lvl;
        ctrl_rdata[7]            = ctrl_q.tx_dma_en;
        ctrl_rdata[0 +: LVL_W]   = ctrl_q.ae_lvl;
    end

    assign push      = dir_rx ? eng_push  : cpu_wr;
    assign push_data = dir_rx ? eng_wdata : cpu_wdata;
    assign pop       = dir_rx ? cpu_rd    : eng_pop;

    tfq_store #(.W(DATA_W), .N(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head_data (rd_data),
        .count     (fill_count)
    );

    tfq_thresh #(.LW(LVL_W)) u_thresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_active (xfer_active),
        .dir_rx      (dir_rx),
        .count       (fill_count),
        .rx_dma_en   (ctrl_q.rx_dma_en),
        .af_lvl      (ctrl_q.af_lvl),
        .tx_dma_en   (ctrl_q.tx_dma_en),
        .ae_lvl      (ctrl_q.ae_lvl),
        .rx_svc_flag (rx_svc_flag),
        .tx_svc_flag (tx_svc_flag),
        .rx_dma_req  (rx_dma_req),
        .tx_dma_req  (tx_dma_req)
    );

    // R7: setting a DMA enable clears the matching flag on the next cycle
    a_r7_rx_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[15]) |=> !rx_svc_flag);
    a_r7_tx_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[7]) |=> !tx_svc_flag);
    // R2: bits outside the fields always read zero
    a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[14:13] == 2'b00 && ctrl_rdata[6:5] == 2'b00));
endmodule

// File: tb/tb_tfq_top.sv
module tb_tfq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_active = 1'b0, dir_rx = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic [15:0] ctrl_rdata;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0, eng_push = 1'b0, eng_pop = 1'b0;
    logic [15:0] cpu_wdata = '0, eng_wdata = '0;
    logic [15:0] rd_data;
    logic [5:0]  fill_count;
    logic        rx_svc_flag, tx_svc_flag, rx_dma_req, tx_dma_req;

    int          n_chk = 0, n_bad = 0, exp_cnt = 0;
    logic [15:0] sb_q[$];
    bit          done = 1'b0;

    always #4 clk = ~clk;

    tfq_top dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // outputs sampled at a falling edge: {count, rxflag, txflag, rxreq, txreq}
    task automatic chk_out(input string tag, input int cnt, input logic [3:0] svc);
        @(negedge clk);
        chk({tag, " count"}, 32'(fill_count), 32'(cnt));
        chk({tag, " svc"}, {28'd0, rx_svc_flag, tx_svc_flag, rx_dma_req, tx_dma_req},
            {28'd0, svc});
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(posedge clk); #1;
        ctrl_wr = 1'b0;
    endtask

    // driver: push through the side the current direction selects
    task automatic push(input logic [15:0] d);
        @(negedge clk);
        if (dir_rx) begin eng_push = 1'b1; eng_wdata = d; end
        else        begin cpu_wr   = 1'b1; cpu_wdata = d; end
        @(posedge clk); #1;
        eng_push = 1'b0; cpu_wr = 1'b0;
        if (exp_cnt < 32) begin sb_q.push_back(d); exp_cnt++; end
    endtask

    // monitor side: compare the head word against the scoreboard on each pop
    task automatic pop(input string tag);
        @(negedge clk);
        if (dir_rx) cpu_rd = 1'b1; else eng_pop = 1'b1;
        if (exp_cnt > 0) begin
            chk(tag, 32'(rd_data), 32'(sb_q.pop_front()));
            exp_cnt--;
        end
        @(posedge clk); #1;
        cpu_rd = 1'b0; eng_pop = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R3 reset state
        @(negedge clk);
        chk("R3 ctrl reset", 32'(ctrl_rdata), 32'h1F00);
        chk_out("R3", 0, 4'b0000);

        // R2 layout and readback
        wr_ctrl(16'hFFFF);
        @(negedge clk) chk("R2 readback all ones", 32'(ctrl_rdata), 32'h9F9F);
        wr_ctrl(16'h8A05);
        @(negedge clk) chk("R2 readback fields", 32'(ctrl_rdata), 32'h8A05);

        // R6 idle, empty: quiet even with ae = 31 in transmit
        dir_rx = 1'b0; xfer_active = 1'b0;
        wr_ctrl(16'h1F1F);
        chk_out("R6 idle empty", 0, 4'b0000);
        xfer_active = 1'b1;
        chk_out("R5 active below ae", 0, 4'b0100);

        // R5 transmit threshold, ae = 4
        wr_ctrl(16'h1F04);
        repeat (3) push(16'h1000 + 16'(exp_cnt));
        chk_out("R5 count 3 below 4", 3, 4'b0100);
        push(16'h1003);
        chk_out("R5 count 4 not below 4", 4, 4'b0000);
        pop("R1 first tx word");
        chk_out("R5 count 3 again", 3, 4'b0100);
        // R7 enable tx DMA while flag is up
        wr_ctrl(16'h1F84);
        chk_out("R7 tx flag to request", 3, 4'b0001);

        // R8 overfill after head moved: 29 fit, 8 dropped
        for (int i = 0; i < 37; i++) push(16'hA000 + 16'(i));
        chk_out("R8 full after overfill", 32, 4'b0000);
        // R1 drain in order across the wrap
        for (int i = 0; i < 32; i++) pop("R1 order across wrap");
        chk_out("R1 drained", 0, 4'b0001);

        // R9 empty pop
        @(negedge clk) held = rd_data;
        pop("R9 empty pop");
        @(negedge clk);
        chk("R9 rd_data held", 32'(rd_data), 32'(held));
        chk("R9 count held", 32'(fill_count), 32'd0);

        // R4 receive threshold, af = 2
        dir_rx = 1'b1;
        wr_ctrl(16'h0200);
        chk_out("R4 empty active rx", 0, 4'b0000);
        // R10 processor write ignored in receive
        @(negedge clk) begin cpu_wr = 1'b1; cpu_wdata = 16'hDEAD; end
        @(posedge clk); #1 cpu_wr = 1'b0;
        chk_out("R10 cpu_wr ignored in rx", 0, 4'b0000);
        push(16'hB000); push(16'hB001);
        chk_out("R4 count 2 not above 2", 2, 4'b0000);
        push(16'hB002);
        chk_out("R4 count 3 above 2", 3, 4'b1000);
        wr_ctrl(16'h8200);
        chk_out("R7 rx flag to request", 3, 4'b0010);
        pop("R1 rx word");
        chk_out("R4 count 2 request drops", 2, 4'b0000);

        // R10 same-cycle push and pop
        @(negedge clk);
        eng_push = 1'b1; eng_wdata = 16'hC0DE; cpu_rd = 1'b1;
        chk("R10 head during push+pop", 32'(rd_data), 32'(sb_q.pop_front()));
        sb_q.push_back(16'hC0DE);
        @(posedge clk); #1;
        eng_push = 1'b0; cpu_rd = 1'b0;
        chk_out("R10 count unchanged", 2, 4'b0000);
        // R10 engine pop ignored in receive
        @(negedge clk) eng_pop = 1'b1;
        @(posedge clk); #1 eng_pop = 1'b0;
        chk_out("R10 eng_pop ignored in rx", 2, 4'b0000);
        pop("R1 rx tail a"); pop("R1 rx tail b");
        xfer_active = 1'b0;
        wr_ctrl(16'h0000);
        chk_out("R6 idle empty after rx", 0, 4'b0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule